// File: doc/BRIEF.md
# Multi-domain reset release sequencer

This block turns one master power-up reset into an ordered start-up of three subsystems: a control processor, an RF interface and a DSP. After the master reset is removed, the block turns on each domain's clock enable. It then holds that domain's active-low reset for a set number of ticks of a 13 MHz reference strobe before releasing it. The processor and RF interface use a fixed delay. The DSP delay comes from a register that software can write.

A supervisory watchdog starts counting once the processor has left reset. If the processor does not pulse the service strobe within the timeout, the watchdog gates off the processor and DSP clocks and re-asserts their resets for a minimum pulse width. After that pulse, both domains go through their power-up release delays again. The RF interface is never touched by the watchdog. All counting advances only on the reference tick. Master reset acts asynchronously, and every release is synchronous.

Top module: `rst_release_seq`

## Requirements
- R1: On the first tick after master reset is released, the processor and DSP clock enables rise together. The RF interface clock enable rises on the following tick.
- R2: While master reset is low, all six outputs are low, and they drop without waiting for a clock edge. Afterwards, clock enables and reset releases change only in response to a tick.
- R3: The processor reset releases exactly CPU_DELAY ticks (default 256) after the tick on which its clock enable rose. The RF interface reset releases CPU_DELAY ticks after its own clock-enable tick.
- R4: The DSP reset releases exactly D ticks after its clock-enable tick. D is the 8-bit delay value in use, from 0 to 255, and D = 0 releases on that same tick. The delay register comes out of master reset holding 255.
- R5: The watchdog fires on the tick that completes WD_TIMEOUT ticks without a service strobe. The clock cycle after that tick, the processor and DSP resets and clock enables go low together.
- R6: A service strobe restarts the timeout count, so strobes spaced closer than WD_TIMEOUT ticks keep both resets released.
- R7: The RF interface clock enable and reset, once high, stay high until the next master reset, whatever the watchdog does.
- R8: A watchdog reset lasts WD_PULSE ticks. The processor and DSP clock enables rise again WD_PULSE+1 ticks after the firing tick, and the R3 and R4 delays then repeat.
- R9: A write to the delay register (`dly_wr` with `dly_wdata`) does not affect the sequence in progress. It is captured during the next watchdog pulse, and master reset restores 255.
- R10: The watchdog counts only while the processor reset is released. The timeout is measured from the processor's release tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Master power-up reset, active low, asynchronous |
| tick | input | 1 | One-cycle 13 MHz reference strobe |
| dly_wr | input | 1 | Write strobe for the DSP delay register |
| dly_wdata | input | DSP_DLY_W | New DSP release delay in ticks |
| wd_kick | input | 1 | Watchdog service strobe from the processor |
| cpu_clk_en | output | 1 | Processor clock enable |
| dsp_clk_en | output | 1 | DSP clock enable |
| rfi_clk_en | output | 1 | RF interface clock enable |
| cpu_rst_n | output | 1 | Processor reset, active low |
| dsp_rst_n | output | 1 | DSP reset, active low |
| rfi_rst_n | output | 1 | RF interface reset, active low |

## Verification
The bench sweeps the DSP delay over its low end (0 to 7), its top end (250 to 254) and midpoints, and ends on a value other than 255. A delay compare that is off by one, or that mishandles zero, shifts the measured release tick. A deferral mistake shows up as a sequence that uses the freshly written value instead of the old one. Every firing is timed against the processor release tick, or against the last service strobe. A watchdog that counts while the processor is held, restarts on the wrong strobe, or shortens the pulse moves the fall or restart tick. The RF interface is watched for any drop across repeated firings. A final mid-run master reset checks that all outputs fall without a clock edge and that the default delay comes back.

// File: rtl/rrs_pkg.sv
package rrs_pkg;

  typedef enum logic {
    WD_RUN  = 1'b0,
    WD_FIRE = 1'b1
  } wd_state_e;

endpackage

// File: rtl/rrs_domain.sv
// One reset domain: clock enable plus counted reset release.
module rrs_domain #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          hold,
  input  logic          go,
  input  logic [DW-1:0] delay,
  output logic          clk_en,
  output logic          rst_out_n
);

  logic          en_q, en_d;
  logic          rel_q, rel_d;
  logic [DW-1:0] cnt_q, cnt_d;
  logic [DW:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt_q} + {{DW{1'b0}}, 1'b1};

  always_comb begin
    en_d  = en_q;
    rel_d = rel_q;
    cnt_d = cnt_q;
    if (hold) begin
      en_d  = 1'b0;
      rel_d = 1'b0;
      cnt_d = '0;
    end else if (tick) begin
      if (!en_q) begin
        if (go) begin
          en_d  = 1'b1;
          rel_d = (delay == '0);
          cnt_d = '0;
        end
      end else if (!rel_q) begin
        rel_d = (cnt_inc == {1'b0, delay});
        cnt_d = cnt_inc[DW-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      rel_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      en_q  <= en_d;
      rel_q <= rel_d;
      cnt_q <= cnt_d;
    end
  end

  assign clk_en    = en_q;
  assign rst_out_n = rel_q;

  // reset is only released with the domain clock running
  assert_rel_needs_clk_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rel_q |-> en_q);

  // clock start only happens on a reference tick
  assert_start_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_q) |-> $past(tick));

  // a hold request shuts the domain down on the next edge
  assert_hold_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (!en_q && !rel_q));

endmodule

// File: rtl/rrs_wdog.sv
// Supervisory watchdog: counts reference ticks while armed, then holds.
module rrs_wdog
  import rrs_pkg::*;
#(
  parameter int TIMEOUT = 6_500_000,
  parameter int PULSE   = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic armed,
  input  logic kick,
  output logic hold
);

  localparam int TCW = $clog2(TIMEOUT + 1);
  localparam int PCW = $clog2(PULSE + 1);
  localparam logic [TCW-1:0] T_LAST = TCW'(TIMEOUT - 1);
  localparam logic [PCW-1:0] P_LAST = PCW'(PULSE - 1);

  wd_state_e      st_q, st_d;
  logic [TCW-1:0] cnt_q, cnt_d;
  logic [PCW-1:0] pc_q, pc_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    pc_d  = pc_q;
    case (st_q)
      WD_RUN: begin
        if (!armed || kick) begin
          cnt_d = '0;
        end else if (tick) begin
          if (cnt_q == T_LAST) begin
            st_d  = WD_FIRE;
            cnt_d = '0;
            pc_d  = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      WD_FIRE: begin
        if (tick) begin
          if (pc_q == P_LAST) st_d = WD_RUN;
          else                pc_d = pc_q + 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= WD_RUN;
      cnt_q <= '0;
      pc_q  <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      pc_q  <= pc_d;
    end
  end

  assign hold = (st_q == WD_FIRE);

  // firing is only possible while the processor was out of reset
  assert_fire_when_armed_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold) |-> $past(armed));

  // a service strobe outside the pulse prevents a firing on the next edge
  assert_kick_defers_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (kick && !hold) |=> !hold);

  // the pulse ends only on a tick
  assert_pulse_ends_on_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold) |-> $past(tick));

endmodule

// File: rtl/rst_release_seq.sv
// Top: ordered reset release for processor, RF interface and DSP domains.
module rst_release_seq #(
  parameter int CPU_DELAY     = 256,
  parameter int DSP_DLY_W     = 8,
  parameter int DSP_DLY_RESET = 255,
  parameter int WD_TIMEOUT    = 6_500_000,
  parameter int WD_PULSE      = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 dly_wr,
  input  logic [DSP_DLY_W-1:0] dly_wdata,
  input  logic                 wd_kick,
  output logic                 cpu_clk_en,
  output logic                 dsp_clk_en,
  output logic                 rfi_clk_en,
  output logic                 cpu_rst_n,
  output logic                 dsp_rst_n,
  output logic                 rfi_rst_n
);

  localparam int CPU_CW = $clog2(CPU_DELAY + 1);
  localparam logic [CPU_CW-1:0]    CPU_DLY_V = CPU_CW'(CPU_DELAY);
  localparam logic [DSP_DLY_W-1:0] DSP_RST_V = DSP_DLY_W'(DSP_DLY_RESET);

  logic                 wd_hold;
  logic [DSP_DLY_W-1:0] dly_reg_q, dly_reg_d;
  logic [DSP_DLY_W-1:0] dly_live_q, dly_live_d;

  // written value is staged and only adopted during a watchdog pulse
  always_comb begin
    dly_reg_d  = dly_wr  ? dly_wdata : dly_reg_q;
    dly_live_d = wd_hold ? dly_reg_q : dly_live_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly_reg_q  <= DSP_RST_V;
      dly_live_q <= DSP_RST_V;
    end else begin
      dly_reg_q  <= dly_reg_d;
      dly_live_q <= dly_live_d;
    end
  end

  rrs_domain #(.DW(CPU_CW)) u_cpu (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .hold      (wd_hold),
    .go        (1'b1),
    .delay     (CPU_DLY_V),
    .clk_en    (cpu_clk_en),
    .rst_out_n (cpu_rst_n)
  );

  rrs_domain #(.DW(DSP_DLY_W)) u_dsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .hold      (wd_hold),
    .go        (1'b1),
    .delay     (dly_live_q),
    .clk_en    (dsp_clk_en),
    .rst_out_n (dsp_rst_n)
  );

  // RF interface starts one tick behind the processor, never held by the watchdog
  rrs_domain #(.DW(CPU_CW)) u_rfi (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .hold      (1'b0),
    .go        (cpu_clk_en),
    .delay     (CPU_DLY_V),
    .clk_en    (rfi_clk_en),
    .rst_out_n (rfi_rst_n)
  );

  rrs_wdog #(.TIMEOUT(WD_TIMEOUT), .PULSE(WD_PULSE)) u_wdog (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .armed (cpu_rst_n),
    .kick  (wd_kick),
    .hold  (wd_hold)
  );

  assert_rfi_rst_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rfi_rst_n |=> rfi_rst_n);

  assert_rfi_clk_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rfi_clk_en |=> rfi_clk_en);

  assert_cpu_dsp_drop_together_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_clk_en) |-> (!dsp_clk_en && !dsp_rst_n && !cpu_rst_n));

  assert_cpu_dsp_start_together_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_clk_en) |-> $rose(dsp_clk_en));

endmodule

// File: tb/test_rst_release_seq.sv
`timescale 1ns/1ps
module test_rst_release_seq;

  localparam int CPU_DELAY = 256;
  localparam int TO        = 16;
  localparam int PW        = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick;
  logic       dly_wr;
  logic [7:0] dly_wdata;
  logic       wd_kick;
  logic       cpu_clk_en, dsp_clk_en, rfi_clk_en;
  logic       cpu_rst_n, dsp_rst_n, rfi_rst_n;

  rst_release_seq #(
    .CPU_DELAY(CPU_DELAY), .DSP_DLY_W(8), .DSP_DLY_RESET(255),
    .WD_TIMEOUT(TO), .WD_PULSE(PW)
  ) i_rst_release_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .dly_wr(dly_wr),
    .dly_wdata(dly_wdata), .wd_kick(wd_kick),
    .cpu_clk_en(cpu_clk_en), .dsp_clk_en(dsp_clk_en), .rfi_clk_en(rfi_clk_en),
    .cpu_rst_n(cpu_rst_n), .dsp_rst_n(dsp_rst_n), .rfi_rst_n(rfi_rst_n)
  );

  always #4 clk = ~clk;

  int n_checks = 0;
  int n_err    = 0;
  int tk = 0;
  int div = 0;
  bit kick_req = 0, wr_req = 0;
  logic [7:0] wr_val = 8'd0;
  int kick_tk = 0;
  int r_cpuen, r_dspen, r_rfien, r_cpurel, r_dsprel, r_rfirel, f_cpu, f_dsp;
  int n_cpuen = 0, n_dspen = 0, n_cpurel = 0, n_dsprel = 0, n_cpufall = 0, n_rfifall = 0;
  logic p_cpuen = 0, p_dspen = 0, p_rfien = 0, p_cpurel = 0, p_dsprel = 0, p_rfirel = 0;

  task automatic check_eq(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  endtask

  // tick generation, event timestamping and strobe driving, all at negedge
  always @(negedge clk) begin
    bit was;
    was = tick;
    if (was) tk++;
    if (cpu_clk_en && !p_cpuen) begin r_cpuen = tk; n_cpuen++; end
    if (dsp_clk_en && !p_dspen) begin r_dspen = tk; n_dspen++; end
    if (rfi_clk_en && !p_rfien) r_rfien = tk;
    if (cpu_rst_n && !p_cpurel) begin r_cpurel = tk; n_cpurel++; end
    if (dsp_rst_n && !p_dsprel) begin r_dsprel = tk; n_dsprel++; end
    if (rfi_rst_n && !p_rfirel) r_rfirel = tk;
    if (!cpu_rst_n && p_cpurel) begin f_cpu = tk; n_cpufall++; end
    if (!dsp_rst_n && p_dsprel) f_dsp = tk;
    if (rst_n && ((!rfi_rst_n && p_rfirel) || (!rfi_clk_en && p_rfien))) n_rfifall++;
    p_cpuen = cpu_clk_en; p_dspen = dsp_clk_en; p_rfien = rfi_clk_en;
    p_cpurel = cpu_rst_n; p_dsprel = dsp_rst_n; p_rfirel = rfi_rst_n;
    wd_kick = 1'b0;
    dly_wr  = 1'b0;
    if (was && kick_req) begin wd_kick = 1'b1; kick_tk = tk; kick_req = 0; end
    if (was && wr_req)   begin dly_wr = 1'b1; dly_wdata = wr_val; wr_req = 0; end
    div  = (div == 2) ? 0 : div + 1;
    tick = (div == 2);
  end

  initial begin
    #(8 * 190000);
    n_checks++; n_err++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int base, cur, nxt, c;
    rst_n = 1'b0; tick = 1'b0; dly_wr = 1'b0; dly_wdata = 8'd0; wd_kick = 1'b0;
    repeat (5) @(posedge clk);
    #1;
    // R2: everything low in master reset
    check_eq("R2 reset outputs", {cpu_clk_en, dsp_clk_en, rfi_clk_en, cpu_rst_n, dsp_rst_n, rfi_rst_n}, 0);
    rst_n = 1'b1;
    base = tk;

    wait (n_cpurel == 1);
    check_eq("R1 cpu clock first tick", r_cpuen, base + 1);
    check_eq("R1 dsp clock with cpu", r_dspen, base + 1);
    check_eq("R1 rfi clock one tick later", r_rfien, base + 2);
    check_eq("R3 cpu release delay", r_cpurel - r_cpuen, CPU_DELAY);
    check_eq("R4 default dsp delay 255", r_dsprel - r_dspen, 255);
    wait (rfi_rst_n);
    @(posedge clk); #1;
    check_eq("R3 rfi release delay", r_rfirel - r_rfien, CPU_DELAY);

    // R6: regular service keeps resets released
    for (int j = 0; j < 6; j++) begin
      int tgt;
      tgt = tk + TO - 4;
      wait (tk == tgt);
      kick_req = 1;
      wait (!kick_req);
    end
    check_eq("R6 no firing while serviced", n_cpufall, 0);
    wait (n_cpufall == 1);
    check_eq("R6 firing timed from last kick", f_cpu, kick_tk + TO);
    check_eq("R5 dsp reset drops with cpu", f_dsp, f_cpu);
    @(posedge clk); #1;
    check_eq("R5 clocks gated in pulse", {cpu_clk_en, dsp_clk_en}, 0);
    check_eq("R7 rfi kept through pulse", {rfi_clk_en, rfi_rst_n}, 3);

    // sweep of DSP delays, each written mid-sequence (R9)
    cur = 255;
    for (int i = 0; i < 15; i++) begin
      if (i < 8)       nxt = i;
      else if (i == 8) nxt = 128;
      else if (i < 14) nxt = 241 + i;
      else             nxt = 100;
      wait (n_dspen == i + 2);
      check_eq("R8 restart after pulse", r_cpuen, f_cpu + PW + 1);
      check_eq("R1 dsp restarts with cpu", r_dspen, r_cpuen);
      wr_val = nxt[7:0]; wr_req = 1;
      wait (!wr_req);
      wait (n_dsprel == i + 2);
      check_eq("R9 R4 dsp delay of this sequence", r_dsprel - r_dspen, cur);
      wait (n_cpurel == i + 2);
      check_eq("R8 R3 cpu delay repeats", r_cpurel - r_cpuen, CPU_DELAY);
      wait (n_cpufall == i + 2);
      check_eq("R10 R5 timeout from cpu release", f_cpu, r_cpurel + TO);
      check_eq("R5 dsp falls with cpu", f_dsp, f_cpu);
      check_eq("R7 rfi never dropped", n_rfifall, 0);
      cur = nxt;
    end

    wait (n_cpurel == 17);
    check_eq("R9 last written delay applied", r_dsprel - r_dspen, 100);
    @(posedge clk); #1;
    rst_n = 1'b0;
    #1;
    check_eq("R2 async assertion", {cpu_clk_en, dsp_clk_en, rfi_clk_en, cpu_rst_n, dsp_rst_n, rfi_rst_n}, 0);
    repeat (3) @(posedge clk);
    #1;
    c = n_dsprel;
    rst_n = 1'b1;
    base = tk;
    wait (n_dsprel == c + 1);
    check_eq("R1 restart after master reset", r_dspen, base + 1);
    check_eq("R9 R4 master reset restores 255", r_dsprel - r_dspen, 255);
    finish_run();
  end

endmodule